// File: doc/BRIEF.md
# Interrupt Event Register Controller

This block keeps the interrupt state of a single-port power controller behind a simple register bus with read and write strobes. Single-cycle pulses from the sensing logic set sticky bits in a bank of event registers, one bank per event group. Each event group also sets a bit in a summary register. A mask register chooses which summary bits may pull the active-low interrupt line.

Each event register can be read at two addresses. A read at the read-only address only reports the bits. A read at the paired clear-on-read address reports them and then clears both the group's event register and its summary bit. A self-clearing command register can clear the summary flags, reset the whole block state, or reset only the port-related event groups. The bench uses five event groups of eight bits. Groups 0 to 3 are port-related. Group 4 is the supply group.

Top module: `iec_top`

## Requirements
- R1: After reset every register reads zero and `intN` is high.
- R2: A 1 on bit b of event group k sets bit b of event register k and bit k of the summary register at address 0x00. Event register k is read-only at address 0x02+2k and clear-on-read at 0x03+2k.
- R3: A read of a read-only event address returns the register and changes no event bit, no summary bit and no interrupt state.
- R4: Read data appears on `regRdData` one cycle after the read strobe. A read of a clear-on-read address returns the value held before the clear, then clears event register k and summary bit k.
- R5: If an event pulse arrives in the same cycle as a clear-on-read of its register, the event register takes the new pulse bits and the summary bit stays set.
- R6: Mask bit k at address 0x01 enables summary bit k. `intN` is low exactly when some enabled summary bit is set. It is registered, so it follows a summary change at the next clock edge.
- R7: Writing command address 0x1A with bit 7 set clears all summary bits and leaves the event registers unchanged. A pulse arriving in the same cycle still sets its summary bit.
- R8: Writing 0x1A with bit 4 set clears all event registers, all summary bits and the mask. This takes priority over same-cycle pulses.
- R9: Writing 0x1A with bit 0 set clears event groups 0 to 3 and their summary bits. The supply group 4 (0x0A/0x0B) is kept.
- R10: Reads of unmapped addresses and of 0x1A return zero. Writes to 0x00 and to 0x02 through 0x0B have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Write data |
| evtIn | input | 40 | Event pulses, group k in bits [8k+7:8k] |
| regRdData | output | 8 | Read data, valid the cycle after a read strobe |
| intN | output | 1 | Active-low interrupt |

## Verification
Two pairs of actions can land in the same cycle: an event pulse together with a clear-on-read of its own register, and an event pulse together with the interrupt-clear command. The bench drives the pulse and the read or write strobe on the same falling edge. Afterwards it reads the read-only copy and the summary register and checks that the new event survived. It also checks that the clear-on-read returned the value held before the clear.

// File: rtl/iec_pkg.sv
package iec_pkg;
  parameter int NUM_EVT = 5;
  parameter int DATA_W = 8;
  parameter int ADDR_W = 8;
  parameter int EVT_BASE = 2;
  parameter int CMD_ADDR = 8'h1A;
  parameter int SUM_ADDR = 8'h00;
  parameter int MASK_ADDR = 8'h01;
  parameter int BIT_CLR_INT = 7;
  parameter int BIT_LOGIC_RST = 4;
  parameter int BIT_PORT_RST = 0;
  parameter logic [NUM_EVT-1:0] PORT_EVT_MASK = 5'b01111;
  localparam int EVT_LAST = EVT_BASE + 2 * NUM_EVT - 1;
  localparam int IDX_W = $clog2(NUM_EVT);

  typedef enum logic [1:0] {RD_NONE, RD_SUM, RD_MASK, RD_EVT} rdSel_t;

  typedef struct packed {
    logic [NUM_EVT-1:0] corRead;
    logic               maskWrite;
    logic               clearInt;
    logic               logicReset;
    logic               portReset;
    logic               rdValid;
    rdSel_t             rdSel;
    logic [IDX_W-1:0]   rdIdx;
  } strobe_t;
endpackage

// File: rtl/iec_ctrl.sv
module iec_ctrl
  import iec_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output strobe_t           stb
);
  logic              isEvt;
  logic [ADDR_W-1:0] offset;
  logic [IDX_W-1:0]  idx;

  assign isEvt  = (regAddr >= ADDR_W'(EVT_BASE)) && (regAddr <= ADDR_W'(EVT_LAST));
  assign offset = regAddr - ADDR_W'(EVT_BASE);
  assign idx    = offset[IDX_W:1];

  always_comb begin
    stb = '0;
    stb.rdValid = regRdEn;
    if (regRdEn) begin
      if (regAddr == ADDR_W'(SUM_ADDR)) stb.rdSel = RD_SUM;
      else if (regAddr == ADDR_W'(MASK_ADDR)) stb.rdSel = RD_MASK;
      else if (isEvt) begin
        stb.rdSel = RD_EVT;
        stb.rdIdx = idx;
        if (regAddr[0]) stb.corRead[idx] = 1'b1;
      end
    end
    if (regWrEn) begin
      if (regAddr == ADDR_W'(MASK_ADDR)) stb.maskWrite = 1'b1;
      if (regAddr == ADDR_W'(CMD_ADDR)) begin
        stb.clearInt   = regWrData[BIT_CLR_INT];
        stb.logicReset = regWrData[BIT_LOGIC_RST];
        stb.portReset  = regWrData[BIT_PORT_RST];
      end
    end
  end
endmodule

// File: rtl/iec_datapath.sv
module iec_datapath
  import iec_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [NUM_EVT*DATA_W-1:0] evtIn,
  output logic [DATA_W-1:0]         rdData,
  output logic                      intN,
  output logic [NUM_EVT-1:0]        sumFlags,
  output logic [NUM_EVT-1:0]        maskBits
);
  logic [DATA_W-1:0] evtBank [NUM_EVT];
  logic [DATA_W-1:0] rdNext;

  for (genvar k = 0; k < NUM_EVT; k++) begin : gEvt
    logic [DATA_W-1:0] evtQ;
    logic              sumQ;
    logic [DATA_W-1:0] pulse;
    logic              wipe;

    assign pulse = evtIn[k*DATA_W +: DATA_W];
    assign wipe  = stb.logicReset || (stb.portReset && PORT_EVT_MASK[k]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        evtQ <= '0;
        sumQ <= 1'b0;
      end else if (wipe) begin
        evtQ <= '0;
        sumQ <= 1'b0;
      end else begin
        evtQ <= (stb.corRead[k] ? '0 : evtQ) | pulse;
        sumQ <= ((stb.corRead[k] || stb.clearInt) ? 1'b0 : sumQ) | (|pulse);
      end
    end

    assign evtBank[k]  = evtQ;
    assign sumFlags[k] = sumQ;
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_SUM:  rdNext = DATA_W'(sumFlags);
      RD_MASK: rdNext = DATA_W'(maskBits);
      RD_EVT:  rdNext = evtBank[stb.rdIdx];
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskBits <= '0;
      rdData   <= '0;
      intN     <= 1'b1;
    end else begin
      if (stb.logicReset) maskBits <= '0;
      else if (stb.maskWrite) maskBits <= wrData[NUM_EVT-1:0];
      if (stb.rdValid) rdData <= rdNext;
      intN <= ~|(sumFlags & maskBits);
    end
  end
endmodule

// File: rtl/iec_top.sv
module iec_top
  import iec_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWrEn,
  input  logic                      regRdEn,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [DATA_W-1:0]         regWrData,
  input  logic [NUM_EVT*DATA_W-1:0] evtIn,
  output logic [DATA_W-1:0]         regRdData,
  output logic                      intN
);
  strobe_t            stb;
  logic [NUM_EVT-1:0] sumFlags;
  logic [NUM_EVT-1:0] maskBits;

  iec_ctrl uCtrl (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .stb(stb)
  );

  iec_datapath uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData), .evtIn(evtIn),
    .rdData(regRdData), .intN(intN), .sumFlags(sumFlags), .maskBits(maskBits)
  );
endmodule

// File: rtl/iec_checker.sv
module iec_checker
  import iec_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic                      regWrEn,
  input logic                      regRdEn,
  input logic [ADDR_W-1:0]         regAddr,
  input logic [DATA_W-1:0]         regWrData,
  input logic [NUM_EVT*DATA_W-1:0] evtIn,
  input logic [DATA_W-1:0]         regRdData,
  input logic                      intN,
  input logic [NUM_EVT-1:0]        sumFlags,
  input logic [NUM_EVT-1:0]        maskBits
);
  localparam logic [ADDR_W-1:0] SUPPLY_COR = ADDR_W'(EVT_BASE + 2 * (NUM_EVT - 1) + 1);

  logic cmdWr, logicRstCmd, roRead, unmappedRead, supplyPulse;
  assign cmdWr        = regWrEn && regAddr == ADDR_W'(CMD_ADDR);
  assign logicRstCmd  = cmdWr && regWrData[BIT_LOGIC_RST];
  assign roRead       = regRdEn && regAddr >= ADDR_W'(EVT_BASE) &&
                        regAddr <= ADDR_W'(EVT_LAST) && !regAddr[0];
  assign unmappedRead = regRdEn && regAddr > ADDR_W'(EVT_LAST);
  assign supplyPulse  = |evtIn[(NUM_EVT-1)*DATA_W +: DATA_W];

  assert_supply_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (supplyPulse && !logicRstCmd) |=> sumFlags[NUM_EVT-1]);

  assert_ro_read_keeps_R3: assert property (@(posedge clk) disable iff (!rstN)
    (roRead && !regWrEn && evtIn == '0) |=> $stable(sumFlags));

  assert_cor_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == SUPPLY_COR && !regWrEn && evtIn == '0) |=> !sumFlags[NUM_EVT-1]);

  assert_pulse_beats_cor_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == SUPPLY_COR && supplyPulse && !logicRstCmd) |=> sumFlags[NUM_EVT-1]);

  assert_no_mask_no_int_R6: assert property (@(posedge clk) disable iff (!rstN)
    (maskBits == '0) |=> intN);

  assert_logic_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    logicRstCmd |=> (sumFlags == '0 && maskBits == '0));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    unmappedRead |=> regRdData == '0);
endmodule

bind iec_top iec_checker uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
  .regWrData(regWrData), .evtIn(evtIn), .regRdData(regRdData), .intN(intN),
  .sumFlags(sumFlags), .maskBits(maskBits)
);

// File: tb/tb_iec_top.sv
module tb_iec_top;
  localparam int NE = 5;
  localparam int DW = 8;

  logic clk = 0;
  logic rstN = 0;
  logic regWrEn = 0, regRdEn = 0;
  logic [7:0] regAddr = 0, regWrData = 0;
  logic [NE*DW-1:0] evtIn = '0;
  logic [7:0] regRdData;
  logic intN;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  iec_top dut (.*);

  always #2 clk = ~clk;

  task automatic check(string req, int got, int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); regRdEn = 1; regAddr = a;
    @(negedge clk); regRdEn = 0; d = regRdData;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = v;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic pulse(input int k, input logic [7:0] v);
    @(negedge clk); evtIn = '0; evtIn[k*DW +: DW] = v;
    @(negedge clk); evtIn = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    check("R1 intN", intN, 1);
    for (int a = 0; a < 32; a++) begin rd(8'(a), d); check("R1 reset read", d, 0); end

    // R2/R3/R4 sweep every group and bit
    for (int k = 0; k < NE; k++)
      for (int b = 0; b < DW; b++) begin
        pulse(k, 8'(1 << b));
        rd(8'(2 + 2*k), d); check("R2 event bit", d, 1 << b);
        rd(8'h00, d); check("R2 summary bit", d, 1 << k);
        rd(8'(2 + 2*k), d); check("R3 ro reread", d, 1 << b);
        rd(8'(3 + 2*k), d); check("R4 cor value", d, 1 << b);
        rd(8'(2 + 2*k), d); check("R4 cleared event", d, 0);
        rd(8'h00, d); check("R4 cleared summary", d, 0);
      end

    // R6 mask sweep
    for (int m = 0; m < NE; m++) begin
      wr(8'h01, 8'(1 << m));
      rd(8'h01, d); check("R6 mask readback", d, 1 << m);
      for (int j = 0; j < NE; j++) begin
        pulse(j, 8'h5A);
        @(negedge clk);
        check("R6 intN", intN, (j == m) ? 0 : 1);
        rd(8'(3 + 2*j), d);
        @(negedge clk); @(negedge clk);
        check("R6 intN released", intN, 1);
      end
    end

    // R5 pulse same cycle as clear-on-read
    pulse(1, 8'h03);
    @(negedge clk); regRdEn = 1; regAddr = 8'h05; evtIn[1*DW +: DW] = 8'h40;
    @(negedge clk); regRdEn = 0; evtIn = '0; d = regRdData;
    check("R5 cor returns old", d, 8'h03);
    rd(8'h04, d); check("R5 new event kept", d, 8'h40);
    rd(8'h00, d); check("R5 summary kept", d, 8'h02);
    rd(8'h05, d);

    // R7 clear interrupt
    wr(8'h01, 8'h1F);
    pulse(2, 8'h81);
    @(negedge clk); check("R7 int before clear", intN, 0);
    wr(8'h1A, 8'h80);
    @(negedge clk);
    rd(8'h00, d); check("R7 summary cleared", d, 0);
    check("R7 intN high", intN, 1);
    rd(8'h06, d); check("R7 event kept", d, 8'h81);
    @(negedge clk); regWrEn = 1; regAddr = 8'h1A; regWrData = 8'h80; evtIn[3*DW +: DW] = 8'h01;
    @(negedge clk); regWrEn = 0; evtIn = '0;
    rd(8'h00, d); check("R7 same-cycle pulse wins", d, 8'h08);
    rd(8'h07, d); rd(8'h09, d);

    // R9 port reset
    for (int k = 0; k < NE; k++) pulse(k, 8'(k + 1));
    wr(8'h1A, 8'h01);
    for (int k = 0; k < NE; k++) begin
      rd(8'(2 + 2*k), d); check("R9 port reset event", d, (k == 4) ? 5 : 0);
    end
    rd(8'h00, d); check("R9 port reset summary", d, 8'h10);
    rd(8'h01, d); check("R9 mask kept", d, 8'h1F);

    // R8 logic reset
    pulse(0, 8'hFF);
    @(negedge clk); regWrEn = 1; regAddr = 8'h1A; regWrData = 8'h10; evtIn[2*DW +: DW] = 8'h01;
    @(negedge clk); regWrEn = 0; evtIn = '0;
    for (int a = 0; a < 12; a++) begin rd(8'(a), d); check("R8 logic reset", d, 0); end
    check("R8 intN", intN, 1);

    // R10 ignored writes and unmapped reads
    pulse(4, 8'h22);
    wr(8'h00, 8'hFF); wr(8'h0A, 8'hFF); wr(8'h0B, 8'h00); wr(8'h03, 8'hFF);
    rd(8'h00, d); check("R10 summary write ignored", d, 8'h10);
    rd(8'h0A, d); check("R10 event write ignored", d, 8'h22);
    rd(8'h02, d); check("R10 event write ignored", d, 0);
    rd(8'h1A, d); check("R10 command reads zero", d, 0);
    for (int a = 12; a < 256; a++) begin rd(8'(a), d); check("R10 unmapped", d, 0); end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule